// File: doc/BRIEF.md
# Level-1 Triggered Event Capture Buffer

This block sits behind a four-channel digitizer and takes one 5-bit sample per channel on every clock. Every sample goes into a circular delay memory, so the stream can be looked at again a programmable number of clocks later. When a level-1 trigger arrives, the block copies a window of delayed samples into one of five event slots. The window starts at the sample that was presented "latency" clocks before the trigger and runs for a programmable number of clocks.

Finished events leave the block in the order they were accepted, over a valid/ready word stream. Each event is framed by a header word and a trailer word. The block refuses a trigger, and counts it as dropped, when every slot is occupied or when a capture is already in progress. A busy flag tells the trigger source that no slot is free. A configuration bit can swap the digitizer samples for a test-pattern input.

Top module: `l1_event_buffer`

## Requirements
- R1: After reset, rd_valid_o and busy_o are low. The configuration defaults are latency 16, window length 4 and live input, so a trigger issued without any configuration write yields a 4-sample event taken with latency 16.
- R2: With latency L and length N, a trigger sampled in clock T stores the input vectors presented in clocks T−L through T−L+N−1, in that order. L can be anything from 1 to 255 and N anything from 2 to 80.
- R3: An event is emitted as one header, then N data words, then one trailer, each 22 bits wide. Bits 21:20 are a tag: 01 for the header, 00 for data, 10 for the trailer. The header carries the event number in bits 7:0 and N in bits 14:8. A data word carries the 20-bit sample vector in bits 19:0, with channel c in bits 5c+4:5c. The trailer carries the event number in bits 7:0 and, in bits 15:8, the dropped-trigger count as it stood when the event was accepted. All unlisted bits are zero.
- R4: A write to cfg_addr 0 sets the latency, and a written 0 becomes 1. A write to cfg_addr 1 sets the length, clamped to 2..80. A write to cfg_addr 2 sets test-input select from bit 0.
- R5: While test select is 1, tst_i is stored in place of adc_i.
- R6: Up to five events are held at once. They are read out in acceptance order, and the event number rises by one (mod 256) for each accepted trigger.
- R7: busy_o goes high in the clock after the fifth slot is taken. It stays high until the trailer of the oldest event is accepted, and falls in the clock after that handshake.
- R8: A trigger that arrives while all five slots are full changes no stored event and uses up no event number. It increments the dropped count.
- R9: A trigger that arrives while a capture is running is dropped in the same way. A trigger in clock T+N, after a capture that began in clock T, is accepted, and its window follows on directly from the previous one.
- R10: While rd_valid_o is high and rd_ready_i is low, rd_data_o holds steady. Words advance only on a handshake, and rd_valid_o is low whenever no event is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_i | input | 20 | Live samples, four channels of 5 bits |
| tst_i | input | 20 | Test-pattern samples |
| trig_i | input | 1 | Level-1 trigger, one clock per trigger |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| rd_valid_o | output | 1 | Event word available |
| rd_ready_i | input | 1 | Consumer accepts the word |
| rd_data_o | output | 22 | Tagged event word |
| busy_o | output | 1 | All event slots occupied |

## Verification
The bench builds the block with its default parameters: four channels of 5 bits, an 8-bit latency field, five slots and a maximum window of 80. With these values both latency extremes (1 and 255) and the longest window fall within a few hundred clocks of settling, and five slots fill after only a handful of triggers. Each scenario rebuilds the expected window independently from a known, bijective input sequence. The scenarios cover both latency extremes, clamped configuration values, test-input selection, full-pool drops, overlapping and back-to-back triggers, and a stalled trailer that must keep the slot held.

// File: rtl/l1eb_pkg.sv
`timescale 1ns/1ps
package l1eb_pkg;
    typedef enum logic [1:0] {PH_HDR = 2'd0, PH_DAT = 2'd1, PH_TRL = 2'd2} rd_phase_e;
    localparam logic [1:0] TAG_DAT = 2'b00;
    localparam logic [1:0] TAG_HDR = 2'b01;
    localparam logic [1:0] TAG_TRL = 2'b10;
endpackage

// File: rtl/l1eb_cfg.sv
`timescale 1ns/1ps
module l1eb_cfg #(
    parameter int LAT_W   = 8,
    parameter int LEN_W   = 7,
    parameter int MIN_LEN = 2,
    parameter int MAX_LEN = 80,
    parameter int LAT_DEF = 16,
    parameter int LEN_DEF = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [LAT_W-1:0] wdata,
    output logic [LAT_W-1:0] lat,
    output logic [LEN_W-1:0] len,
    output logic             tst
);
    typedef struct packed {
        logic [LAT_W-1:0] lat;
        logic [LEN_W-1:0] len;
        logic             tst;
    } cfg_t;

    cfg_t q, d;

    always_comb begin
        d = q;
        if (we) begin
            unique case (addr)
                2'd0: d.lat = (wdata == '0) ? LAT_W'(1) : wdata;
                2'd1: begin
                    if (wdata < LAT_W'(MIN_LEN))      d.len = LEN_W'(MIN_LEN);
                    else if (wdata > LAT_W'(MAX_LEN)) d.len = LEN_W'(MAX_LEN);
                    else                              d.len = LEN_W'(wdata);
                end
                2'd2: d.tst = wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.lat <= LAT_W'(LAT_DEF);
            q.len <= LEN_W'(LEN_DEF);
            q.tst <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign lat = q.lat;
    assign len = q.len;
    assign tst = q.tst;
endmodule

// File: rtl/l1eb_delay.sv
`timescale 1ns/1ps
module l1eb_delay #(
    parameter int W  = 20,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] lat,
    output logic [W-1:0]  dout
);
    localparam int DEPTH = 2 ** AW;

    logic [W-1:0]  ring [DEPTH];
    logic [AW-1:0] wp_q, wp_d;

    always_comb wp_d = wp_q + AW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) wp_q <= '0;
        else        wp_q <= wp_d;
    end

    always_ff @(posedge clk) ring[wp_q] <= din;

    // entry written lat clocks ago
    assign dout = ring[wp_q - lat];
endmodule

// File: rtl/l1eb_store.sv
`timescale 1ns/1ps
module l1eb_store #(
    parameter int W       = 20,
    parameter int NSLOT   = 5,
    parameter int MAX_LEN = 80
) (
    input  logic                       clk,
    input  logic                       we,
    input  logic [$clog2(NSLOT)-1:0]   wslot,
    input  logic [$clog2(MAX_LEN)-1:0] widx,
    input  logic [W-1:0]               wdata,
    input  logic [$clog2(NSLOT)-1:0]   rslot,
    input  logic [$clog2(MAX_LEN)-1:0] ridx,
    output logic [W-1:0]               rdata
);
    localparam int ENTRIES = NSLOT * MAX_LEN;
    localparam int AW      = $clog2(ENTRIES);

    logic [W-1:0]  mem [ENTRIES];
    logic [AW-1:0] waddr, raddr;

    assign waddr = AW'(wslot) * AW'(MAX_LEN) + AW'(widx);
    assign raddr = AW'(rslot) * AW'(MAX_LEN) + AW'(ridx);

    always_ff @(posedge clk) if (we) mem[waddr] <= wdata;

    assign rdata = mem[raddr];
endmodule

// File: rtl/l1_event_buffer.sv
`timescale 1ns/1ps
module l1_event_buffer
    import l1eb_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int SW      = 5,
    parameter int LAT_W   = 8,
    parameter int NSLOT   = 5,
    parameter int MIN_LEN = 2,
    parameter int MAX_LEN = 80,
    parameter int LAT_DEF = 16,
    parameter int LEN_DEF = 4,
    parameter int EVN_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCH*SW-1:0]          adc_i,
    input  logic [NCH*SW-1:0]          tst_i,
    input  logic                       trig_i,
    input  logic                       cfg_we,
    input  logic [1:0]                 cfg_addr,
    input  logic [LAT_W-1:0]           cfg_wdata,
    output logic                       rd_valid_o,
    input  logic                       rd_ready_i,
    output logic [NCH*SW+1:0]          rd_data_o,
    output logic                       busy_o
);
    localparam int WW    = NCH * SW;
    localparam int OW    = WW + 2;
    localparam int LEN_W = $clog2(MAX_LEN + 1);
    localparam int IDX_W = $clog2(MAX_LEN);
    localparam int SL_W  = $clog2(NSLOT);
    localparam int CNT_W = $clog2(NSLOT + 1);

    typedef struct packed {
        logic [CNT_W-1:0]                  cnt;
        logic [SL_W-1:0]                   wr_slot;
        logic [SL_W-1:0]                   rd_slot;
        logic                              cap;
        logic [IDX_W-1:0]                  cap_idx;
        logic [LEN_W-1:0]                  cap_len;
        logic [NSLOT-1:0][LEN_W-1:0]       s_len;
        logic [NSLOT-1:0][EVN_W-1:0]       s_evn;
        logic [NSLOT-1:0][EVN_W-1:0]       s_drp;
        logic [EVN_W-1:0]                  evn;
        logic [EVN_W-1:0]                  drops;
        rd_phase_e                         ph;
        logic [IDX_W-1:0]                  rd_idx;
    } ctl_t;

    ctl_t q, d;

    logic [LAT_W-1:0] cfg_lat;
    logic [LEN_W-1:0] cfg_len;
    logic             cfg_tst;
    logic [WW-1:0]    live, delayed, ev_rdata;
    logic             ev_we, accept, release_ev, fire;
    logic [IDX_W-1:0] ev_widx;
    logic [CNT_W-1:0] done;

    function automatic logic [SL_W-1:0] nxt(input logic [SL_W-1:0] s);
        return (s == SL_W'(NSLOT - 1)) ? '0 : s + SL_W'(1);
    endfunction

    l1eb_cfg #(
        .LAT_W(LAT_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN),
        .LAT_DEF(LAT_DEF), .LEN_DEF(LEN_DEF)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .lat(cfg_lat), .len(cfg_len), .tst(cfg_tst)
    );

    assign live = cfg_tst ? tst_i : adc_i;

    l1eb_delay #(.W(WW), .AW(LAT_W)) u_dly (
        .clk(clk), .rst_n(rst_n), .din(live), .lat(cfg_lat), .dout(delayed)
    );

    l1eb_store #(.W(WW), .NSLOT(NSLOT), .MAX_LEN(MAX_LEN)) u_store (
        .clk(clk), .we(ev_we), .wslot(q.wr_slot), .widx(ev_widx), .wdata(delayed),
        .rslot(q.rd_slot), .ridx(q.rd_idx), .rdata(ev_rdata)
    );

    always_comb begin
        d          = q;
        ev_we      = 1'b0;
        ev_widx    = '0;
        release_ev = 1'b0;
        done       = q.cnt - CNT_W'(q.cap);
        accept     = trig_i && !q.cap && (q.cnt != CNT_W'(NSLOT));

        // capture side
        if (accept) begin
            ev_we                = 1'b1;
            ev_widx              = '0;
            d.s_len[q.wr_slot]   = cfg_len;
            d.s_evn[q.wr_slot]   = q.evn;
            d.s_drp[q.wr_slot]   = q.drops;
            d.evn                = q.evn + EVN_W'(1);
            d.cap                = 1'b1;
            d.cap_len            = cfg_len;
            d.cap_idx            = IDX_W'(1);
        end else begin
            if (trig_i) d.drops = q.drops + EVN_W'(1);
            if (q.cap) begin
                ev_we     = 1'b1;
                ev_widx   = q.cap_idx;
                d.cap_idx = q.cap_idx + IDX_W'(1);
                if (q.cap_idx == IDX_W'(q.cap_len - LEN_W'(1))) begin
                    d.cap     = 1'b0;
                    d.wr_slot = nxt(q.wr_slot);
                end
            end
        end

        // readout side
        rd_valid_o = (done != '0);
        fire       = rd_valid_o && rd_ready_i;
        unique case (q.ph)
            PH_HDR:  rd_data_o = {TAG_HDR, WW'({q.s_len[q.rd_slot], q.s_evn[q.rd_slot]})};
            PH_DAT:  rd_data_o = {TAG_DAT, ev_rdata};
            PH_TRL:  rd_data_o = {TAG_TRL, WW'({q.s_drp[q.rd_slot], q.s_evn[q.rd_slot]})};
            default: rd_data_o = '0;
        endcase
        if (fire) begin
            unique case (q.ph)
                PH_HDR: begin
                    d.ph     = PH_DAT;
                    d.rd_idx = '0;
                end
                PH_DAT: begin
                    if (q.rd_idx == IDX_W'(q.s_len[q.rd_slot] - LEN_W'(1))) d.ph = PH_TRL;
                    else d.rd_idx = q.rd_idx + IDX_W'(1);
                end
                PH_TRL: begin
                    d.ph       = PH_HDR;
                    d.rd_slot  = nxt(q.rd_slot);
                    release_ev = 1'b1;
                end
                default: d.ph = PH_HDR;
            endcase
        end

        d.cnt = q.cnt + CNT_W'(accept) - CNT_W'(release_ev);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = (q.cnt == CNT_W'(NSLOT));
endmodule

// File: rtl/l1eb_chk.sv
`timescale 1ns/1ps
module l1eb_chk #(
    parameter int OW = 22
) (
    input logic          clk,
    input logic          rst_n,
    input logic          trig_i,
    input logic          busy_o,
    input logic          rd_valid_o,
    input logic          rd_ready_i,
    input logic [OW-1:0] rd_data_o
);
    logic trl_fire, hdr_fire;
    assign trl_fire = rd_valid_o && rd_ready_i && (rd_data_o[OW-1:OW-2] == 2'b10);
    assign hdr_fire = rd_valid_o && rd_ready_i && (rd_data_o[OW-1:OW-2] == 2'b01);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o)));

    // R3
    tag_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> (rd_data_o[OW-1:OW-2] != 2'b11));

    // R3
    hdr_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_fire |=> (rd_valid_o && rd_data_o[OW-1:OW-2] == 2'b00));

    // R7
    full_has_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> rd_valid_o);

    // R7
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(trl_fire));

    // R8
    full_trig_keeps_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && trig_i && !trl_fire) |=> busy_o);
endmodule

bind l1_event_buffer l1eb_chk #(.OW(OW)) u_chk (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .busy_o(busy_o),
    .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i), .rd_data_o(rd_data_o)
);

// File: tb/sim_l1_event_buffer.sv
`timescale 1ns/1ps
module sim_l1_event_buffer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [19:0] adc_i, tst_i;
    logic        trig_i, cfg_we, rd_ready_i;
    logic [1:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic        rd_valid_o, busy_o;
    logic [21:0] rd_data_o;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int evn_m = 0;
    int drp_m = 0;

    always #2.5 clk = ~clk;

    l1_event_buffer u0 (
        .clk(clk), .rst_n(rst_n), .adc_i(adc_i), .tst_i(tst_i), .trig_i(trig_i),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i), .rd_data_o(rd_data_o),
        .busy_o(busy_o)
    );

    typedef struct packed {
        logic [7:0] lat_w;
        logic [7:0] len_w;
        logic [7:0] lat_e;
        logic [7:0] len_e;
        logic       tst;
        logic       tog;
    } vec_t;

    // written values, expected effective values, test select, ready toggling
    localparam vec_t VECS [6] = '{
        '{8'd1,   8'd2,   8'd1,   8'd2,  1'b0, 1'b0},
        '{8'd255, 8'd80,  8'd255, 8'd80, 1'b0, 1'b1},
        '{8'd0,   8'd1,   8'd1,   8'd2,  1'b0, 1'b0},
        '{8'd37,  8'd200, 8'd37,  8'd80, 1'b0, 1'b0},
        '{8'd20,  8'd9,   8'd20,  8'd9,  1'b1, 1'b1},
        '{8'd3,   8'd79,  8'd3,   8'd79, 1'b0, 1'b1}
    };

    function automatic logic [19:0] pat(input int n);
        return 20'(n * 40503 + 4660);
    endfunction

    task automatic tick();
        @(negedge clk);
        cyc++;
        adc_i = pat(cyc);
        tst_i = ~pat(cyc);
    endtask

    task automatic chk(input string req, input logic [21:0] act, input logic [21:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic cfg_wr(input logic [1:0] a, input logic [7:0] v);
        tick();
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic trig_at(output int t);
        tick();
        trig_i = 1'b1;
        t = cyc;
        tick();
        trig_i = 1'b0;
    endtask

    task automatic read_ev(input string req, input int en, input int len, input int first,
                           input int dr, input bit tst, input bit tog, input bit stall_trl);
        int k = 0;
        int guard = 0;
        int stalls = 0;
        logic [21:0] exp;
        while (k < len + 2 && guard < 2000) begin
            tick();
            guard++;
            if (k == 0)        exp = {2'b01, 5'b0, 7'(len), 8'(en)};
            else if (k <= len) exp = {2'b00, tst ? ~pat(first + k - 1) : pat(first + k - 1)};
            else               exp = {2'b10, 4'b0, 8'(dr), 8'(en)};
            if (stall_trl && k == len + 1 && stalls < 4) begin
                rd_ready_i = 1'b0;
                stalls++;
                // R7: slot still held while trailer waits; R10: word steady
                chk("R7 busy during trailer stall", {21'b0, busy_o}, 22'd1);
                chk("R10 trailer held", rd_data_o, exp);
            end else begin
                rd_ready_i = tog ? cyc[0] : 1'b1;
                if (rd_valid_o && rd_ready_i) begin
                    chk(req, rd_data_o, exp);
                    k++;
                end
            end
        end
        if (guard >= 2000) begin
            checks++; fails++;
            $display("FAIL %s: event incomplete, got %0d words expected %0d", req, k, len + 2);
        end
        tick();
        rd_ready_i = 1'b0;
    endtask

    initial begin
        #750000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int t1, t2, tx;
        int tf [5];
        int dsnap;
        rst_n = 1'b0; trig_i = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        rd_ready_i = 1'b0; adc_i = '0; tst_i = '0;
        repeat (5) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 valid after reset", {21'b0, rd_valid_o}, 22'd0);
        chk("R1 busy after reset", {21'b0, busy_o}, 22'd0);
        repeat (300) tick();
        trig_at(t1);
        read_ev("R1 defaults", evn_m, 4, t1 - 16, drp_m, 1'b0, 1'b0, 1'b0);
        evn_m++;

        // table walk: R2 R3 R4 R5
        foreach (VECS[i]) begin
            cfg_wr(2'd0, VECS[i].lat_w);
            cfg_wr(2'd1, VECS[i].len_w);
            cfg_wr(2'd2, {7'b0, VECS[i].tst});
            repeat (300) tick();
            trig_at(t1);
            read_ev((i == 2 || i == 3) ? "R4 clamp" : (VECS[i].tst ? "R5 test input" : "R2 R3 window"),
                    evn_m, int'(VECS[i].len_e), t1 - int'(VECS[i].lat_e), drp_m,
                    VECS[i].tst, VECS[i].tog, 1'b0);
            evn_m++;
        end

        // R6 R7 R8: fill all slots with the consumer stalled
        cfg_wr(2'd0, 8'd10);
        cfg_wr(2'd1, 8'd3);
        cfg_wr(2'd2, 8'd0);
        repeat (300) tick();
        dsnap = drp_m;
        for (int i = 0; i < 5; i++) begin
            if (i == 4) chk("R7 busy low with one slot free", {21'b0, busy_o}, 22'd0);
            trig_at(tf[i]);
            repeat (3) tick();
        end
        chk("R7 busy after fifth event", {21'b0, busy_o}, 22'd1);
        trig_at(tx);
        drp_m++;
        tick();
        chk("R8 busy after dropped trigger", {21'b0, busy_o}, 22'd1);
        read_ev("R6 oldest event", evn_m, 3, tf[0] - 10, dsnap, 1'b0, 1'b0, 1'b1);
        chk("R7 busy released after trailer", {21'b0, busy_o}, 22'd0);
        for (int i = 1; i < 5; i++)
            read_ev("R6 R8 queued event", evn_m + i, 3, tf[i] - 10, dsnap, 1'b0, 1'b1, 1'b0);
        evn_m += 5;
        repeat (3) tick();
        chk("R8 dropped trigger left no event", {21'b0, rd_valid_o}, 22'd0);

        // R9: overlapping trigger dropped, back-to-back trigger accepted
        cfg_wr(2'd1, 8'd10);
        repeat (30) tick();
        dsnap = drp_m;
        trig_at(t1);
        tick();
        tick();
        trig_i = 1'b1;
        tick();
        trig_i = 1'b0;
        drp_m++;
        while (cyc < t1 + 9) tick();
        trig_at(t2);
        chk("R9 back-to-back trigger clock", 22'(t2 - t1), 22'd10);
        read_ev("R9 first window", evn_m, 10, t1 - 10, dsnap, 1'b0, 1'b1, 1'b0);
        read_ev("R9 contiguous window", evn_m + 1, 10, t2 - 10, drp_m, 1'b0, 1'b0, 1'b0);
        evn_m += 2;
        repeat (3) tick();
        chk("R10 valid low when empty", {21'b0, rd_valid_o}, 22'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule